// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where control goes next in a small microcontroller with a 64 KB program space. A decode stage hands it the current instruction address, the instruction length, a form code and the instruction's address or offset fields. It also supplies the accumulator, the data pointer and a branch-taken flag. From these the block returns the next program-counter value and, for computed code-memory reads, the byte address to read.

All arithmetic is built around the address of the instruction that follows. This is the current address plus the length, and it is called the sequential address below.

- Relative offsets are added to the sequential address.
- The paged form keeps the sequential address's upper five bits and takes its lower eleven bits from the instruction.
- Results are registered. A request presented with `req_vld` is answered one clock later with `rsp_vld`.
- The outputs hold their value until the next request.

Top module: `branch_target_gen`

## Requirements
- R1: While reset is applied, and until the first request after reset, `rsp_vld`, `next_pc` and `code_addr` are all 0.
- R2: The form code selects the operation as follows: 0 = sequential, 1 = long absolute, 2 = paged absolute, 3 = short relative, 4 = conditional relative, 5 = code read at data pointer, 6 = code read at PC, 7 = reserved. Forms 0 and 7 give `next_pc` = `cur_pc` + `instr_len`.
- R3: Form 1 gives `next_pc` = `abs_fld`, which may be any of the 65536 addresses.
- R4: Form 2 gives `next_pc` = {sequential[15:11], `abs_fld`[10:0]}. The page is taken from the following instruction, even when that instruction lies in the next 2 KB page.
- R5: Form 3 gives `next_pc` = sequential + sign-extended `rel_ofs` (range -128 to +127).
- R6: Form 4 gives `next_pc` = sequential + sign-extended `rel_ofs` when `taken` is 1, and `next_pc` = sequential when `taken` is 0.
- R7: Form 5 gives `code_addr` = `dptr` + zero-extended `acc`, and `next_pc` = sequential.
- R8: Form 6 gives `code_addr` = sequential + zero-extended `acc`, and `next_pc` = sequential.
- R9: For forms 0 to 4 and 7, `code_addr` is 0.
- R10: A request accepted at a clock edge updates both outputs and raises `rsp_vld` for exactly the following cycle. When `req_vld` is low, `next_pc` and `code_addr` hold their values.
- R11: All address sums wrap modulo 65536.
- R12: `taken` has no effect on any form other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| req_vld | input | 1 | Request strobe; also the register enable |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes (1 to 3) |
| form | input | 3 | Control-transfer form code |
| abs_fld | input | 16 | Absolute destination field (the paged form uses bits 10:0) |
| rel_ofs | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| taken | input | 1 | Condition result for the conditional form |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| next_pc | output | 16 | Next program-counter value |
| code_addr | output | 16 | Effective code-memory read address |

## Verification
A wrong sequential sum or a wrong page splice shows up on `next_pc` one cycle after the request that used it. A sign or carry error shows up the same way, but only for offsets past the sign boundary or for addresses near the top of the range. A stale or unenabled register shows up as a `next_pc` or `code_addr` that moves in the idle cycle after a response. The sweep therefore covers every offset and accumulator byte, every length and every form, at base addresses chosen at a page edge and at the wrap point.

// File: rtl/btag_pkg.sv
package btag_pkg;
  typedef enum logic [2:0] {
    FORM_SEQ     = 3'd0,
    FORM_LONG    = 3'd1,
    FORM_PAGE    = 3'd2,
    FORM_SHORT   = 3'd3,
    FORM_COND    = 3'd4,
    FORM_CODE_DP = 3'd5,
    FORM_CODE_PC = 3'd6,
    FORM_RSVD    = 3'd7
  } form_e;
endpackage

// File: rtl/btag_seq_adder.sv
module btag_seq_adder #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [LEN_W-1:0] instr_len,
  output logic [PC_W-1:0]  seq_pc
);
  localparam int PAD_W = PC_W - LEN_W;

  always_comb begin
    seq_pc = cur_pc + {{PAD_W{1'b0}}, instr_len};
  end
endmodule

// File: rtl/btag_jump_sel.sv
module btag_jump_sel
  import btag_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8
) (
  input  form_e             form,
  input  logic [PC_W-1:0]   seq_pc,
  input  logic [PC_W-1:0]   abs_fld,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic              taken,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;

  always_comb begin
    rel_tgt  = seq_pc + {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
    page_tgt = {seq_pc[PC_W-1:PAGE_W], abs_fld[PAGE_W-1:0]};
    unique case (form)
      FORM_LONG:  target = abs_fld;
      FORM_PAGE:  target = page_tgt;
      FORM_SHORT: target = rel_tgt;
      FORM_COND:  target = taken ? rel_tgt : seq_pc;
      default:    target = seq_pc;
    endcase
  end
endmodule

// File: rtl/btag_code_addr.sv
module btag_code_addr
  import btag_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int ACC_W = 8
) (
  input  form_e            form,
  input  logic [PC_W-1:0]  seq_pc,
  input  logic [PC_W-1:0]  dptr,
  input  logic [ACC_W-1:0] acc,
  output logic [PC_W-1:0]  code_addr
);
  localparam int PAD_W = PC_W - ACC_W;

  logic [PC_W-1:0] acc_ext;

  always_comb begin
    acc_ext = {{PAD_W{1'b0}}, acc};
    unique case (form)
      FORM_CODE_DP: code_addr = dptr + acc_ext;
      FORM_CODE_PC: code_addr = seq_pc + acc_ext;
      default:      code_addr = '0;
    endcase
  end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import btag_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int ACC_W  = 8,
  parameter int LEN_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [2:0]        form,
  input  logic [PC_W-1:0]   abs_fld,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ACC_W-1:0]  acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              taken,
  output logic              rsp_vld,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   code_addr
);
  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_N-1];

  form_e           form_q;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_d;
  logic [PC_W-1:0] caddr_d;

  assign form_q = form_e'(form);

  btag_seq_adder #(.PC_W(PC_W), .LEN_W(LEN_W)) seq_i (
    .cur_pc    (cur_pc),
    .instr_len (instr_len),
    .seq_pc    (seq_pc)
  );

  btag_jump_sel #(.PC_W(PC_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) jsel_i (
    .form    (form_q),
    .seq_pc  (seq_pc),
    .abs_fld (abs_fld),
    .rel_ofs (rel_ofs),
    .taken   (taken),
    .target  (tgt_d)
  );

  btag_code_addr #(.PC_W(PC_W), .ACC_W(ACC_W)) caddr_i (
    .form      (form_q),
    .seq_pc    (seq_pc),
    .dptr      (dptr),
    .acc       (acc),
    .code_addr (caddr_d)
  );

  // next-state
  logic            vld_d;
  logic [PC_W-1:0] npc_d;
  logic [PC_W-1:0] cad_d;

  always_comb begin
    vld_d = req_vld;
    npc_d = next_pc;
    cad_d = code_addr;
    if (req_vld) begin
      npc_d = tgt_d;
      cad_d = caddr_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_vld   <= 1'b0;
      next_pc   <= '0;
      code_addr <= '0;
    end else begin
      rsp_vld   <= vld_d;
      next_pc   <= npc_d;
      code_addr <= cad_d;
    end
  end
endmodule

// File: rtl/btag_checker.sv
module btag_checker #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int ACC_W  = 8,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [PC_W-1:0]   cur_pc,
  input logic [LEN_W-1:0]  instr_len,
  input logic [2:0]        form,
  input logic [PC_W-1:0]   abs_fld,
  input logic [OFS_W-1:0]  rel_ofs,
  input logic [ACC_W-1:0]  acc,
  input logic [PC_W-1:0]   dptr,
  input logic              taken,
  input logic              rsp_vld,
  input logic [PC_W-1:0]   next_pc,
  input logic [PC_W-1:0]   code_addr
);
  logic [PC_W-1:0] seq_c;
  logic [PC_W-1:0] rel_c;
  logic [PC_W-1:0] dp_c;
  assign seq_c = cur_pc + PC_W'(instr_len);
  assign rel_c = seq_c + PC_W'(signed'(rel_ofs));
  assign dp_c  = dptr + PC_W'(acc);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);  // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && $stable(next_pc) && $stable(code_addr)));  // R10
  AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && form == 3'd1) |=> next_pc == $past(abs_fld));  // R3
  AST_PAGE_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && form == 3'd2) |=> (next_pc[PC_W-1:PAGE_W] == $past(seq_c[PC_W-1:PAGE_W])
                                   && next_pc[PAGE_W-1:0] == $past(abs_fld[PAGE_W-1:0])));  // R4
  AST_SHORT_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && form == 3'd3) |=> next_pc == $past(rel_c));  // R5
  AST_COND_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && form == 3'd4 && !taken) |=> next_pc == $past(seq_c));  // R6
  AST_CODE_DPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && form == 3'd5) |=> code_addr == $past(dp_c));  // R7
  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (form < 3'd5 || form == 3'd7)) |=> code_addr == '0);  // R9
endmodule

bind branch_target_gen btag_checker #(
  .PC_W(PC_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n_int), .req_vld(req_vld), .cur_pc(cur_pc),
  .instr_len(instr_len), .form(form), .abs_fld(abs_fld), .rel_ofs(rel_ofs),
  .acc(acc), .dptr(dptr), .taken(taken), .rsp_vld(rsp_vld),
  .next_pc(next_pc), .code_addr(code_addr)
);

// File: tb/branch_target_gen_tb_top.sv
module branch_target_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [15:0] cur_pc;
  logic [1:0]  instr_len;
  logic [2:0]  form;
  logic [15:0] abs_fld;
  logic [7:0]  rel_ofs;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic        taken;
  logic        rsp_vld;
  logic [15:0] next_pc;
  logic [15:0] code_addr;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  branch_target_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .cur_pc(cur_pc),
    .instr_len(instr_len), .form(form), .abs_fld(abs_fld), .rel_ofs(rel_ofs),
    .acc(acc), .dptr(dptr), .taken(taken), .rsp_vld(rsp_vld),
    .next_pc(next_pc), .code_addr(code_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures < 20)
        $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int f, input bit tk);
    case (f)
      1: return "R3";
      2: return "R4";
      3: return tk ? "R5" : "R12";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return tk ? "R2" : "R12";
    endcase
  endfunction

  task automatic one_req(input int pc, input int len, input int f, input int v,
                         input bit tk, input int dp);
    int seq, rel, enpc, ecad, hold_n, hold_c;
    int absv;
    absv = ((v << 8) | (v ^ 8'hA5)) & 16'hFFFF;
    seq  = (pc + len) & 16'hFFFF;
    rel  = (seq + ((v > 127) ? v - 256 : v)) & 16'hFFFF;
    case (f)
      1: enpc = absv;
      2: enpc = (seq & 16'hF800) | (absv & 16'h07FF);
      3: enpc = rel;
      4: enpc = tk ? rel : seq;
      default: enpc = seq;
    endcase
    case (f)
      5: ecad = (dp + v) & 16'hFFFF;
      6: ecad = (seq + v) & 16'hFFFF;
      default: ecad = 0;
    endcase
    @(negedge clk);
    req_vld = 1'b1; cur_pc = 16'(pc); instr_len = 2'(len); form = 3'(f);
    abs_fld = 16'(absv); rel_ofs = 8'(v); acc = 8'(v); dptr = 16'(dp); taken = tk;
    @(negedge clk);
    req_vld = 1'b0;
    chk(rsp_vld == 1'b1, "R10", int'(rsp_vld), 1);
    chk(int'(next_pc) == enpc, tag_of(f, tk), int'(next_pc), enpc);
    chk(int'(code_addr) == ecad, (f == 5 || f == 6) ? tag_of(f, tk) : "R9",
        int'(code_addr), ecad);
    hold_n = int'(next_pc); hold_c = int'(code_addr);
    // scramble idle inputs; outputs must not follow them
    cur_pc = ~cur_pc; abs_fld = ~abs_fld; acc = ~acc; form = 3'd1;
    @(negedge clk);
    chk(rsp_vld == 1'b0 && int'(next_pc) == hold_n && int'(code_addr) == hold_c,
        "R10", int'(next_pc), hold_n);
  endtask

  initial begin
    int pcs [4];
    pcs = '{16'h0000, 16'h07FE, 16'h1234, 16'hFFFE};
    rst_n = 1'b0; req_vld = 1'b0; cur_pc = '0; instr_len = 2'd1; form = '0;
    abs_fld = '0; rel_ofs = '0; acc = '0; dptr = '0; taken = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_vld == 1'b0 && next_pc == 16'h0 && code_addr == 16'h0, "R1",
        int'(next_pc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_vld == 1'b0 && next_pc == 16'h0 && code_addr == 16'h0, "R1",
        int'(next_pc), 0);
    // page crossing: following instruction lands in next page (R4)
    one_req(16'h07FF, 2, 2, 8'h12, 1'b0, 0);
    // wrap at top of space (R11)
    one_req(16'hFFFF, 1, 0, 0, 1'b1, 0);
    one_req(16'hFFFE, 2, 3, 8'h7F, 1'b1, 0);
    one_req(16'h0000, 1, 3, 8'h80, 1'b1, 0);
    one_req(16'h0000, 1, 5, 8'hFF, 1'b0, 16'hFFF0);
    for (int pi = 0; pi < 4; pi++)
      for (int len = 1; len <= 3; len++)
        for (int f = 0; f < 8; f++)
          for (int tk = 0; tk < 2; tk++)
            for (int v = 0; v < 256; v++)
              one_req(pcs[pi], len, f, v, tk[0], (pcs[pi] ^ 16'hFF80) & 16'hFFFF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule